// File: doc/BRIEF.md
# PCM Sample Buffer with Replay Mode

This block holds PCM sample bytes on their way from a host to a playback engine. The host pushes bytes into a 4096-byte buffer through a byte stream port. It reads and writes one 8-bit control register. On a read, that register reports the full and empty status together with the stored sample format and volume. On a write, the top two bits are a command: clear the buffer, or arm a replay mode. The playback engine pulls one byte per request strobe. The format and volume fields are exported as plain pins for a mixer further down the chain.

In normal mode each playback request consumes the oldest byte. In replay mode a separate play position walks the buffered bytes without discarding them. When it reaches the newest byte it jumps back to the oldest retained byte, so a short clip repeats for as long as replay stays armed. Host writes still append during replay. When replay is disarmed, consumption resumes from the current play position, and the bytes already passed are dropped.

The input stream has no true back-pressure. `s_ready` is low while the buffer is full, and a byte presented with `s_valid` high in that state is discarded. The host is not expected to hold the byte. The playback side returns each byte one cycle after its request, flagged by `pb_valid`. The playback side has no back-pressure on the returned byte.

Top module: `pcm_loop_fifo`

## Requirements
- R1: The buffer holds 4096 bytes. After 4096 accepted writes, bit 7 of `ctl_rdata` reads 1 and `s_ready` is 0. Below that occupancy, bit 7 reads 0.
- R2: A byte offered with `s_valid` high while the buffer is full is discarded. The buffer contents and order are unchanged.
- R3: Bit 6 of `ctl_rdata` reads 1 exactly when the buffer holds no bytes, including right after reset. After reset `ctl_rdata` is 0x40.
- R4: A control write with bit 7 = 1 and bit 6 = 0 empties the buffer in that cycle. A stream byte offered in that same cycle is dropped.
- R5: A control write with bits 7 and 6 both 1 arms replay mode (`loop_active` = 1) and keeps the buffered bytes.
- R6: Any control write whose bits 7:6 are not 11 disarms replay mode.
- R7: Every control write stores bit 5 (16-bit samples), bit 4 (stereo) and bits 3:0 (volume). These read back in the same bit positions and drive `fmt_wide`, `fmt_stereo` and `pcm_volume`.
- R8: In normal mode, a `pb_req` on a non-empty buffer returns the oldest byte on `pb_data` with `pb_valid` high in the next cycle, and removes that byte.
- R9: In replay mode, requests return the buffered bytes in order. After the newest byte, the next request returns the oldest retained byte. No byte is removed.
- R10: In replay mode, stream writes append behind the newest byte, and the following replay passes include them.
- R11: When replay is disarmed, the next request returns the byte after the last one played. Bytes before it are gone.
- R12: A `pb_req` on an empty buffer returns `pb_data` = 0 with `pb_valid` and `pb_underrun` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host offers a sample byte |
| s_ready | output | 1 | Buffer can take a byte (low when full) |
| s_data | input | 8 | Sample byte |
| pb_req | input | 1 | Playback pulls one byte |
| pb_valid | output | 1 | Response to the previous cycle's request |
| pb_data | output | 8 | Returned byte, zero on underrun |
| pb_underrun | output | 1 | Previous request found the buffer empty |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_rdata | output | 8 | {full, empty, wide, stereo, volume[3:0]} |
| fmt_wide | output | 1 | 16-bit sample format selected |
| fmt_stereo | output | 1 | Stereo selected |
| pcm_volume | output | 4 | PCM volume |
| loop_active | output | 1 | Replay mode armed |

## Verification
The main function is exercised with three input patterns.

- A short clip is read in normal order. It is then replayed several laps, extended by a write during replay, and the replay is finally disarmed in mid-lap. This separates consuming reads from replaying reads, and shows whether disarming resumes from the play position or from the oldest byte.
- A full 4096-byte ramp is written, one byte is offered while full, and all bytes are read back. This separates a correct full boundary and drop from an off-by-one or an overwrite.
- Control writes are sent with each value of the top two bits. This tells a clear from an arm from a plain disarm. A clear issued together with a stream byte shows whether that byte leaks into the buffer.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  // control register bit positions (the host decodes these)
  localparam int CtlFullBit  = 7;
  localparam int CtlEmptyBit = 6;
  localparam int CtlWideBit  = 5;
  localparam int CtlStBit    = 4;

  typedef enum logic [1:0] {
    CMD_PLAIN  = 2'b00,
    CMD_PLAIN2 = 2'b01,
    CMD_CLEAR  = 2'b10,
    CMD_LOOP   = 2'b11
  } ctl_cmd_e;

  typedef struct packed {
    logic       wide;
    logic       stereo;
    logic [3:0] vol;
  } pcm_fmt_t;
endpackage

// File: rtl/pcm_ctl_reg.sv
module pcm_ctl_reg
  import pcm_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output pcm_fmt_t   fmt_q,
  output logic       loop_q,
  output logic       clr_o,
  output logic       loop_exit_o
);
  ctl_cmd_e cmd;

  always_comb begin
    cmd         = ctl_cmd_e'(ctl_wdata[CtlFullBit:CtlEmptyBit]);
    clr_o       = ctl_we && (cmd == CMD_CLEAR);
    loop_exit_o = ctl_we && (cmd != CMD_LOOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      loop_q <= 1'b0;
    end else if (ctl_we) begin
      fmt_q  <= pcm_fmt_t'(ctl_wdata[CtlWideBit:0]);
      loop_q <= (cmd == CMD_LOOP);
    end
  end

  // R5
  loop_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7] && ctl_wdata[6]) |=> loop_q);

  // R6
  loop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !(ctl_wdata[7] && ctl_wdata[6])) |=> !loop_q);

  // R7
  fmt_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (fmt_q == $past(ctl_wdata[5:0])));
endmodule

// File: rtl/pcm_ptr_ctl.sv
module pcm_ptr_ctl #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          clr,
  input  logic          loop_q,
  input  logic          loop_exit,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic          rd_hit,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wptr, rptr, pptr;
  logic [PW-1:0] count, pptr_step, pptr_nxt, rptr_nxt;

  always_comb begin
    count     = wptr - rptr;
    full      = (count == PW'(DEPTH));
    empty     = (count == '0);
    wr_en     = wr_req && !full && !clr;
    rd_hit    = rd_req && !empty;
    waddr     = wptr[AW-1:0];
    raddr     = pptr[AW-1:0];
    pptr_step = pptr + PW'(1);
    if (!rd_hit)
      pptr_nxt = pptr;
    else if (loop_q && (pptr_step == wptr))
      pptr_nxt = rptr;
    else
      pptr_nxt = pptr_step;
    rptr_nxt = (loop_q && !loop_exit) ? rptr : pptr_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
      pptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + PW'(1);
      pptr <= pptr_nxt;
      rptr <= rptr_nxt;
    end
  end

  // R1
  occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> $stable(wptr));

  // R4
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && pptr == '0));

  // R9
  loop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !loop_exit && !clr) |=> (count >= $past(count)));
endmodule

// File: rtl/pcm_sample_ram.sv
module pcm_sample_ram #(
  parameter int DW = 8,
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcm_loop_fifo.sv
module pcm_loop_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       pb_req,
  output logic       pb_valid,
  output logic [7:0] pb_data,
  output logic       pb_underrun,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       fmt_wide,
  output logic       fmt_stereo,
  output logic [3:0] pcm_volume,
  output logic       loop_active
);
  pcm_fmt_t      fmt;
  logic          loop_q, clr, loop_exit;
  logic          wr_en, rd_hit, full, empty, hit_q;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    ram_q;

  pcm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fmt_q(fmt), .loop_q(loop_q), .clr_o(clr), .loop_exit_o(loop_exit)
  );

  pcm_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_req(s_valid), .rd_req(pb_req), .clr(clr),
    .loop_q(loop_q), .loop_exit(loop_exit), .wr_en(wr_en), .waddr(waddr),
    .rd_hit(rd_hit), .raddr(raddr), .full(full), .empty(empty)
  );

  pcm_sample_ram #(.DW(8), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(s_data),
    .re(rd_hit), .raddr(raddr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_valid    <= 1'b0;
      pb_underrun <= 1'b0;
      hit_q       <= 1'b0;
    end else begin
      pb_valid    <= pb_req;
      pb_underrun <= pb_req && empty;
      hit_q       <= rd_hit;
    end
  end

  always_comb begin
    s_ready     = !full;
    pb_data     = hit_q ? ram_q : 8'h00;
    ctl_rdata   = {full, empty, fmt};
    fmt_wide    = fmt.wide;
    fmt_stereo  = fmt.stereo;
    pcm_volume  = fmt.vol;
    loop_active = loop_q;
  end

  // R12
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && empty) |=> (pb_underrun && pb_valid && pb_data == 8'h00));

  // R3
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[CtlEmptyBit] |-> !ctl_rdata[CtlFullBit]);
endmodule

// File: tb/sim_pcm_loop_fifo.sv
module sim_pcm_loop_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, pb_req = 1'b0, ctl_we = 1'b0;
  logic [7:0] s_data = '0, ctl_wdata = '0;
  logic       s_ready, pb_valid, pb_underrun, fmt_wide, fmt_stereo, loop_active;
  logic [7:0] pb_data, ctl_rdata;
  logic [3:0] pcm_volume;
  int         n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pcm_loop_fifo u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .pb_req(pb_req), .pb_valid(pb_valid), .pb_data(pb_data), .pb_underrun(pb_underrun),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .fmt_wide(fmt_wide), .fmt_stereo(fmt_stereo), .pcm_volume(pcm_volume),
    .loop_active(loop_active)
  );

  // op: 0 write, 1 read expect byte, 2 control write expect readback and loop flag, 3 read expect underrun
  localparam int NV = 27;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h11, 8'h00, 1'b0}, {2'd0, 8'h22, 8'h00, 1'b0}, {2'd0, 8'h33, 8'h00, 1'b0},
    {2'd1, 8'h00, 8'h11, 1'b0},
    {2'd2, 8'hF5, 8'h35, 1'b1},
    {2'd1, 8'h00, 8'h22, 1'b0}, {2'd1, 8'h00, 8'h33, 1'b0},
    {2'd1, 8'h00, 8'h22, 1'b0}, {2'd1, 8'h00, 8'h33, 1'b0},
    {2'd0, 8'h44, 8'h00, 1'b0},
    {2'd1, 8'h00, 8'h22, 1'b0}, {2'd1, 8'h00, 8'h33, 1'b0},
    {2'd1, 8'h00, 8'h44, 1'b0}, {2'd1, 8'h00, 8'h22, 1'b0},
    {2'd2, 8'h12, 8'h12, 1'b0},
    {2'd1, 8'h00, 8'h33, 1'b0}, {2'd1, 8'h00, 8'h44, 1'b0},
    {2'd3, 8'h00, 8'h00, 1'b0},
    {2'd2, 8'h00, 8'h40, 1'b0},
    {2'd2, 8'hC0, 8'h40, 1'b1},
    {2'd3, 8'h00, 8'h00, 1'b0},
    {2'd2, 8'h40, 8'h40, 1'b0},
    {2'd0, 8'h5A, 8'h00, 1'b0},
    {2'd2, 8'hA9, 8'h69, 1'b0},
    {2'd3, 8'h00, 8'h00, 1'b0},
    {2'd0, 8'h66, 8'h00, 1'b0},
    {2'd1, 8'h00, 8'h66, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); s_valid = 1'b1; s_data = d;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic do_read(output logic v, output logic u, output logic [7:0] d);
    @(negedge clk); pb_req = 1'b1;
    @(negedge clk); pb_req = 1'b0;
    v = pb_valid; u = pb_underrun; d = pb_data;
  endtask

  task automatic do_ctl(input logic [7:0] w);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic v, u;
    logic [7:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check(ctl_rdata == 8'h40 && s_ready && !loop_active, "R3 reset", ctl_rdata, 8'h40);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][18:17])
        2'd0: do_write(VEC[i][16:9]);
        2'd1: begin
          do_read(v, u, d);
          // R8 R9 R10 R11 ordered bytes
          check(v && !u && d == VEC[i][8:1], "R8/R9/R10/R11 read", d, VEC[i][8:1]);
        end
        2'd2: begin
          do_ctl(VEC[i][16:9]);
          // R5 R6 R7 control effect
          check(ctl_rdata == VEC[i][8:1] && loop_active == VEC[i][0],
                "R5/R6/R7 ctl", {loop_active, ctl_rdata}, {VEC[i][0], VEC[i][8:1]});
          check({fmt_wide, fmt_stereo, pcm_volume} == VEC[i][14:9], "R7 pins",
                {fmt_wide, fmt_stereo, pcm_volume}, VEC[i][14:9]);
        end
        default: begin
          do_read(v, u, d);
          // R12 underrun
          check(v && u && d == 8'h00, "R12 underrun", {u, d}, 9'h100);
        end
      endcase
    end

    // R1 fill to capacity
    do_read(v, u, d);
    for (int i = 0; i < 4095; i++) begin
      do_write(i[7:0]);
      if (i == 4094) check(!ctl_rdata[7] && s_ready, "R1 below full", ctl_rdata, 8'h00);
    end
    do_write(8'hFF);
    check(ctl_rdata[7] && !s_ready, "R1 full", {s_ready, ctl_rdata[7]}, 2'b01);
    // R2 offered byte while full is dropped
    do_write(8'hAA);
    bad = 0;
    for (int i = 0; i < 4096; i++) begin
      do_read(v, u, d);
      if (!v || u || d != ((i == 4095) ? 8'hFF : i[7:0])) bad++;
    end
    check(bad == 0, "R2 contents after drop", bad, 0);
    check(ctl_rdata[6], "R2/R3 empty after drain", ctl_rdata, 8'h40);

    // R4 clear with concurrent stream byte
    do_write(8'h01); do_write(8'h02); do_write(8'h03);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'h80; s_valid = 1'b1; s_data = 8'h77;
    @(negedge clk);
    ctl_we = 1'b0; s_valid = 1'b0;
    check(ctl_rdata == 8'h40, "R4 clear", ctl_rdata, 8'h40);
    do_read(v, u, d);
    check(u && d == 8'h00, "R4 no leak", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule